// File: doc/BRIEF.md
# Serial Register Write Port with Address Streaming

This block receives register writes over a three-wire serial link: a serial clock, a serial data line and an active-low select line. Every transfer starts with a 12-bit register address and is followed by one or more 28-bit data words. Both fields arrive least significant bit first. The serial signals are brought into the system clock domain through two-flop synchronizers. Rising edges of the serial clock are found by edge detection, and the data line is sampled only at those edges. Because of this the serial clock can rest high or low between transfers.

Each 28-bit word that is received in full produces a one-cycle write strobe toward a register file, together with its address and data. While select stays low, each further word goes to the next higher address, and the address wraps from 0xFFF to 0x000. If select rises in the middle of a word, that word is discarded. The next transfer then starts again with an address phase.

The controller is a three-state machine:
- `ST_IDLE`: deselected.
- `ST_ADDR`: shifting in the address.
- `ST_DATA`: shifting in data words.

Its transitions are:
- T_SELECT: `ST_IDLE`→`ST_ADDR` when select falls.
- T_ADDR_DONE: `ST_ADDR`→`ST_DATA` on the twelfth address bit.
- T_WORD_DONE: `ST_DATA`→`ST_DATA` on the 28th data bit. It raises the strobe and advances the address.
- T_ABORT: `ST_ADDR` or `ST_DATA`→`ST_IDLE` whenever select is high.

The serial clock must be slow enough that each of its high and low phases lasts at least three system clock cycles.

Top module: `serial_regwr_slave`

## Requirements
- R1: After reset, and whenever reset is asserted (including in the middle of a transfer), `wr_stb_o` is 0, `wr_addr_o` is 0x000 and `wr_data_o` is 0x0000000.
- R2: A transfer consists of 12 address bits followed by 28 data bits. The first bit received is address bit 0, and data bit 0 is the first bit after the address. A complete transfer produces exactly one write, with that address and that data.
- R3: `sdin_i` is sampled only at rising edges of `sclk_i`. A change of `sdin_i` while `sclk_i` is high, including a value held across the falling edge, has no effect on the written data.
- R4: The result of a transfer does not depend on whether `sclk_i` rests high or low before and after it.
- R5: If `sel_n_i` rises before all 28 bits of a data word have arrived, that word is not written and the outputs keep their previous values. Any earlier complete words of the same burst are still written.
- R6: While `sel_n_i` stays low, each further complete 28-bit word is written to the address of the previous word plus one.
- R7: Address incrementing wraps from 0xFFF to 0x000.
- R8: A transfer aborted during its address phase produces no write. After any rise of `sel_n_i`, the next transfer starts with a fresh 12-bit address.
- R9: `wr_stb_o` is high for exactly one system clock cycle per completed word.
- R10: A 28-bit word whose upper bits are zero is written with exactly those zero upper bits, so registers narrower than 28 bits are loaded with the full word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous to `clk` |
| sdin_i | input | 1 | Serial data, least significant bit first |
| sel_n_i | input | 1 | Active-low select that frames a transfer or burst |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 12 | Register address of the current write |
| wr_data_o | output | 28 | Data word of the current write |

## Verification
Single-word transfers use data patterns such as a lone low bit, a lone high bit, alternating bits, all ones and a value with zero upper bits. These show that bit order and field boundaries are right: a swapped order or an off-by-one split between address and data changes the captured value. Transfers are run with the serial clock resting high and resting low. One transfer flips the data line while the serial clock is high, which separates rising-edge sampling from falling-edge sampling. Bursts of two and three words, one of them starting at 0xFFE, show the address increment and the wrap. Transfers cut short in the address phase, in the first data word and in a later data word, plus a reset in the middle of a burst, show that partial words are discarded and that framing restarts cleanly.

// File: rtl/srw_pkg.sv
package srw_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 28;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } srw_state_e;
endpackage

// File: rtl/srw_sync.sv
module srw_sync #(
    parameter int                W       = 3,
    parameter int                STAGES  = 2,
    parameter logic [W-1:0]      RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
            else        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
        end
        assign q_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/srw_edge.sv
module srw_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end
    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/srw_fsm.sv
module srw_fsm
    import srw_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_hi_i,
    input  logic          rise_i,
    input  logic          bit_i,
    output logic          stb_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o
);
    localparam int MAXW   = (AW > DW) ? AW : DW;
    localparam int CNT_W  = $clog2(MAXW);
    localparam logic [CNT_W-1:0] A_LAST = CNT_W'(AW - 1);
    localparam logic [CNT_W-1:0] D_LAST = CNT_W'(DW - 1);

    srw_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [AW-1:0]    asr_q;
    logic [DW-1:0]    dsr_q;
    logic             addr_done, word_done;

    assign addr_done = (state_q == ST_ADDR) && !sel_hi_i && rise_i && (cnt_q == A_LAST);
    assign word_done = (state_q == ST_DATA) && !sel_hi_i && rise_i && (cnt_q == D_LAST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!sel_hi_i) state_d = ST_ADDR;      // T_SELECT
            ST_ADDR: begin
                if (sel_hi_i)       state_d = ST_IDLE;      // T_ABORT
                else if (addr_done) state_d = ST_DATA;      // T_ADDR_DONE
            end
            ST_DATA: if (sel_hi_i)  state_d = ST_IDLE;      // T_ABORT; T_WORD_DONE stays
            default:                state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            asr_q <= '0;
            dsr_q <= '0;
        end else if (sel_hi_i) begin
            cnt_q <= '0;
        end else if (rise_i) begin
            unique case (state_q)
                ST_ADDR: begin
                    asr_q <= {bit_i, asr_q[AW-1:1]};
                    cnt_q <= addr_done ? '0 : cnt_q + 1'b1;
                end
                ST_DATA: begin
                    dsr_q <= {bit_i, dsr_q[DW-1:1]};
                    cnt_q <= word_done ? '0 : cnt_q + 1'b1;
                    if (word_done) asr_q <= asr_q + 1'b1;
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_o  <= 1'b0;
            addr_o <= '0;
            data_o <= '0;
        end else begin
            stb_o <= word_done;
            if (word_done) begin
                addr_o <= asr_q;
                data_o <= {bit_i, dsr_q[DW-1:1]};
            end
        end
    end

    // checker state for burst addressing
    logic          burst_q;
    logic [AW-1:0] last_addr_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            burst_q     <= 1'b0;
            last_addr_q <= '0;
        end else begin
            if (stb_o) last_addr_q <= addr_o;
            if (sel_hi_i)   burst_q <= 1'b0;
            else if (stb_o) burst_q <= 1'b1;
        end
    end

    p_stb_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |=> !stb_o);
    p_stb_from_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |-> $past(state_q) == ST_DATA);
    p_stb_needs_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |-> $past(!sel_hi_i));
    p_burst_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o && burst_q) |-> addr_o == last_addr_q + 1'b1);
    p_desel_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hi_i |=> (state_q == ST_IDLE) && (cnt_q == '0));
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ADDR) |-> cnt_q <= A_LAST) and ((state_q == ST_DATA) |-> cnt_q <= D_LAST));
endmodule

// File: rtl/serial_regwr_slave.sv
module serial_regwr_slave
    import srw_pkg::*;
#(
    parameter int AW          = ADDR_W,
    parameter int DW          = DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_i,
    input  logic          sdin_i,
    input  logic          sel_n_i,
    output logic          wr_stb_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o
);
    localparam int NSIG = 3;
    localparam logic [NSIG-1:0] SYNC_RST = 3'b100;  // {sel_n, sdin, sclk}

    logic [NSIG-1:0] raw, synced;
    logic            sclk_rise;

    assign raw = {sel_n_i, sdin_i, sclk_i};

    srw_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (synced)
    );

    srw_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (synced[0]),
        .rise_o (sclk_rise)
    );

    srw_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_hi_i (synced[2]),
        .rise_i   (sclk_rise),
        .bit_i    (synced[1]),
        .stb_o    (wr_stb_o),
        .addr_o   (wr_addr_o),
        .data_o   (wr_data_o)
    );
endmodule

// File: tb/test_serial_regwr_slave.sv
module test_serial_regwr_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        sdin = 1'b0;
    logic        sel_n = 1'b1;
    logic        wr_stb;
    logic [11:0] wr_addr;
    logic [27:0] wr_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    serial_regwr_slave i_serial_regwr_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk),
        .sdin_i    (sdin),
        .sel_n_i   (sel_n),
        .wr_stb_o  (wr_stb),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    // capture of write strobes
    logic [11:0] cap_addr [8];
    logic [27:0] cap_data [8];
    int          n_cap = 0;
    int          hi_run = 0;
    int          max_run = 0;
    always @(negedge clk) begin
        if (wr_stb) begin
            if (n_cap < 8) begin
                cap_addr[n_cap] = wr_addr;
                cap_data[n_cap] = wr_data;
            end
            n_cap++;
            hi_run++;
            if (hi_run > max_run) max_run = hi_run;
        end else hi_run = 0;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [27:0] v, input int n, input bit flip);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b0;
            sdin = v[i];
            #40;
            sclk = 1'b1;
            if (flip) begin
                #20; sdin = ~v[i]; #20;
            end else #40;
        end
    endtask

    task automatic open_frame(input bit idle_hi);
        n_cap = 0; max_run = 0;
        sclk = idle_hi;
        #60; sel_n = 1'b0; #60;
    endtask

    task automatic close_frame(input bit idle_hi);
        sclk = idle_hi;
        #60; sel_n = 1'b1; #100;
    endtask

    typedef struct packed {
        logic        idle_hi;
        logic [11:0] addr;
        logic [1:0]  nw;
        logic [27:0] d0;
        logic [27:0] d1;
        logic [27:0] d2;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b0, 12'h000, 2'd1, 28'h0000001, 28'h0, 28'h0},
        '{1'b1, 12'hA5C, 2'd1, 28'hFEDCBA9, 28'h0, 28'h0},
        '{1'b0, 12'h123, 2'd3, 28'h8000000, 28'h5555555, 28'hAAAAAAA},
        '{1'b1, 12'h7F0, 2'd2, 28'h0000FFF, 28'hFFFFFFF, 28'h0},
        '{1'b0, 12'hFFE, 2'd3, 28'h1111111, 28'h2222222, 28'h3333333},
        '{1'b1, 12'h800, 2'd1, 28'hFFFFFFE, 28'h0, 28'h0}
    };

    initial begin
        #2000000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        // R1: reset state
        chk(wr_stb == 1'b0, "R1 stb in reset", 32'(wr_stb), 0);
        chk(wr_addr == 12'h0 && wr_data == 28'h0, "R1 outputs in reset", 32'(wr_data), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(wr_stb == 1'b0, "R1 stb after reset", 32'(wr_stb), 0);

        // table walk: R2, R4, R6, R7, R10
        for (int v = 0; v < 6; v++) begin
            logic [27:0] dw [3];
            dw[0] = VEC[v].d0; dw[1] = VEC[v].d1; dw[2] = VEC[v].d2;
            open_frame(VEC[v].idle_hi);
            send_bits(28'(VEC[v].addr), 12, 1'b0);
            for (int w = 0; w < int'(VEC[v].nw); w++) send_bits(dw[w], 28, 1'b0);
            close_frame(VEC[v].idle_hi);
            chk(n_cap == int'(VEC[v].nw), "R2 write count", 32'(n_cap), 32'(VEC[v].nw));
            chk(max_run == 1, "R9 strobe width", 32'(max_run), 1);
            for (int w = 0; w < int'(VEC[v].nw) && w < n_cap; w++) begin
                logic [11:0] ea;
                ea = VEC[v].addr + 12'(w);   // R6 step, R7 wrap
                chk(cap_addr[w] == ea, (w == 0) ? "R2 address" : "R6/R7 burst address",
                    32'(cap_addr[w]), 32'(ea));
                chk(cap_data[w] == dw[w], VEC[v].idle_hi ? "R4 data (idle high)" : "R10 data",
                    32'(cap_data[w]), 32'(dw[w]));
            end
        end

        // R3: data line flipped while sclk high
        open_frame(1'b0);
        send_bits(28'h3C5, 12, 1'b1);
        send_bits(28'h9ABCDEF, 28, 1'b1);
        close_frame(1'b0);
        chk(n_cap == 1, "R3 count", 32'(n_cap), 1);
        chk(cap_addr[0] == 12'h3C5, "R3 address", 32'(cap_addr[0]), 32'h3C5);
        chk(cap_data[0] == 28'h9ABCDEF, "R3 data", 32'(cap_data[0]), 32'h9ABCDEF);

        // R5: short first word
        open_frame(1'b0);
        send_bits(28'h055, 12, 1'b0);
        send_bits(28'h00FFFFF, 20, 1'b0);
        close_frame(1'b0);
        chk(n_cap == 0, "R5 short word dropped", 32'(n_cap), 0);
        chk(wr_data == 28'h9ABCDEF && wr_addr == 12'h3C5, "R5 outputs held", 32'(wr_data), 32'h9ABCDEF);

        // R5: full word then partial word
        open_frame(1'b1);
        send_bits(28'h300, 12, 1'b0);
        send_bits(28'h0ABCDEF, 28, 1'b0);
        send_bits(28'h3FF, 10, 1'b0);
        close_frame(1'b1);
        chk(n_cap == 1, "R5 partial tail", 32'(n_cap), 1);
        chk(cap_addr[0] == 12'h300 && wr_data == 28'h0ABCDEF, "R5 first word kept", 32'(wr_data), 32'h0ABCDEF);

        // R8: aborted address phase, then fresh frame
        open_frame(1'b0);
        send_bits(28'h1F, 5, 1'b0);
        close_frame(1'b0);
        chk(n_cap == 0, "R8 aborted address", 32'(n_cap), 0);
        open_frame(1'b0);
        send_bits(28'h0AB, 12, 1'b0);
        send_bits(28'h1234567, 28, 1'b0);
        close_frame(1'b0);
        chk(n_cap == 1 && cap_addr[0] == 12'h0AB, "R8 fresh address", 32'(cap_addr[0]), 32'h0AB);
        chk(cap_data[0] == 28'h1234567, "R8 fresh data", 32'(cap_data[0]), 32'h1234567);

        // R1: reset in the middle of a burst
        open_frame(1'b0);
        send_bits(28'h456, 12, 1'b0);
        send_bits(28'h7654321, 28, 1'b0);
        send_bits(28'h3FF, 10, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(wr_addr == 12'h0 && wr_data == 28'h0 && !wr_stb, "R1 mid-burst reset", 32'(wr_data), 0);
        close_frame(1'b0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        open_frame(1'b0);
        send_bits(28'hFFF, 12, 1'b0);
        send_bits(28'h0000ABC, 28, 1'b0);
        close_frame(1'b0);
        chk(n_cap == 1 && cap_addr[0] == 12'hFFF && cap_data[0] == 28'h0000ABC,
            "R2 frame after reset", 32'(cap_data[0]), 32'hABC);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule